// File: doc/BRIEF.md
# Load/Store Range Watchpoint Comparator

This block sits beside a processor's load/store bus and looks at every data access. Two address comparators and two data comparators each hold a reference value and a relation, strictly greater or strictly less. Pairing two comparators gives an open window. An access that lands inside the address window and carries a value inside the data window raises a watchpoint. The same event also raises a breakpoint, unless a gating mode holds it back while the processor's recoverable-interrupt bit is clear.

The data comparison works in one of two ways. It can treat the bus as one 32-bit word. It can also treat the bus as two 16-bit lanes, each tested against the matching half of the reference. A per-comparator byte mask removes chosen bytes from the comparison. In lane mode, a word access hits when any single lane is inside the window. This false detection is intended behaviour.

Configuration is loaded by simple register writes. A sticky flag remembers that a match has occurred, and writing 1 to the status select clears it.

Top module: `ldst_range_watch`

## Requirements
- R1: Each address comparator tests its reference strictly and unsigned. The relation bit at 1 selects addr > ref, and at 0 selects addr < ref. Comparator A's relation is control bit 0 and comparator B's is control bit 1.
- R2: The address window is the AND of both address comparators. An inclusive lower bound N is programmed as greater-than N-1. For example, greater-than 0x1 with less-than 0xE accepts 0x2 to 0xD and rejects 0x1 and 0xE.
- R3: With control bit 4 at 0 (word mode), the data window is the AND of two strict unsigned 32-bit comparisons. Comparator A's relation is control bit 2 and comparator B's is control bit 3.
- R4: With control bit 4 at 1 (half-word mode), lane 0 (bits 15:0) and lane 1 (bits 31:16) are each tested against the same half of both references. The data window matches when any lane satisfies both comparators.
- R5: Byte mask bit i, when set, removes data byte i (bits 8i+7:8i) from that comparator, on both the access value and the reference. Comparator A's mask is control bits 11:8 and comparator B's is control bits 15:12. A mask of 0 keeps every byte.
- R6: wp_pulse is 1 in the cycle after a sampled access with acc_valid=1 that matches both the address window and the data window, and 0 otherwise.
- R7: Control bit 5 enables the address window and bit 6 enables the data window. A disabled window counts as always matching.
- R8: With gate_mode=1, bp_pulse follows wp_pulse only for accesses sampled with ri_bit=1. With gate_mode=0, bp_pulse always follows wp_pulse. wp_pulse is never gated.
- R9: sticky_hit goes to 1 together with wp_pulse and stays at 1. Writing to select 5 with bit 0 at 1 clears it, and writing 0 there leaves it unchanged. A match in the same cycle as a clear wins.
- R10: Synchronous reset clears the outputs, the references and the control register. Select codes are: 0 address ref A, 1 address ref B, 2 data ref A, 3 data ref B, 4 control, 5 status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| acc_valid | input | 1 | Load/store access present |
| acc_addr | input | 32 | Access address |
| acc_data | input | 32 | Access data value |
| ri_bit | input | 1 | Processor recoverable-interrupt status bit |
| gate_mode | input | 1 | 1 = breakpoint gated by ri_bit |
| wp_pulse | output | 1 | Watchpoint event, one cycle after the access |
| bp_pulse | output | 1 | Breakpoint event, one cycle after the access |
| sticky_hit | output | 1 | Sticky match flag |

## Verification
The address stimulus walks both edges of the inclusive-bound example: one value below each edge, the edge itself, and one value inside. This shows whether the comparisons are strict. The data stimulus uses values equal to either reference, values inside the window in only the high lane or only the low lane, and values outside the window in both lanes. Running the same value in word mode and in half-word mode shows the intended lane false detection. A value that passes only when one byte is masked out shows that the mask acts on both operands. The relation bits are swapped to check the comparator direction. The ri_bit and gate_mode combinations separate the watchpoint from the breakpoint, and writes to the status select, including one in the same cycle as a match, show the clear priority.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
  typedef enum logic { REL_LT = 1'b0, REL_GT = 1'b1 } rel_e;

  localparam logic [2:0] SEL_AREF_A = 3'd0;
  localparam logic [2:0] SEL_AREF_B = 3'd1;
  localparam logic [2:0] SEL_DREF_A = 3'd2;
  localparam logic [2:0] SEL_DREF_B = 3'd3;
  localparam logic [2:0] SEL_CTRL   = 3'd4;
  localparam logic [2:0] SEL_STAT   = 3'd5;

  localparam int CTL_HALF = 4;
  localparam int CTL_AEN  = 5;
  localparam int CTL_DEN  = 6;
  localparam int CTL_MSK  = 8;
endpackage

// File: rtl/lsw_rng_cmp.sv
module lsw_rng_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] val,
  input  logic [W-1:0] refv,
  input  lsw_pkg::rel_e rel,
  output logic         hit
);
  always_comb begin
    if (rel == lsw_pkg::REL_GT) hit = (val > refv);
    else                        hit = (val < refv);
  end
endmodule

// File: rtl/lsw_data_cmp.sv
module lsw_data_cmp #(
  parameter int DW     = 32,
  parameter int LANE_W = 16
) (
  input  logic [DW-1:0]   data,
  input  logic [DW-1:0]   refv,
  input  logic [DW/8-1:0] bmask,
  input  lsw_pkg::rel_e   rel,
  output logic [DW/LANE_W-1:0] lane_hit,
  output logic            word_hit
);
  localparam int NB    = DW / 8;
  localparam int LANES = DW / LANE_W;

  logic [DW-1:0] keep;
  logic [DW-1:0] d_m;
  logic [DW-1:0] r_m;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign keep[8*b +: 8] = {8{~bmask[b]}};
  end

  assign d_m = data & keep;
  assign r_m = refv & keep;

  lsw_rng_cmp #(.W(DW)) u_word (
    .val(d_m), .refv(r_m), .rel(rel), .hit(word_hit)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lsw_rng_cmp #(.W(LANE_W)) u_lane (
      .val (d_m[LANE_W*l +: LANE_W]),
      .refv(r_m[LANE_W*l +: LANE_W]),
      .rel (rel),
      .hit (lane_hit[l])
    );
  end
endmodule

// File: rtl/lsw_cfg_regs.sv
module lsw_cfg_regs #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int WW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [2:0]    sel,
  input  logic [WW-1:0] wdata,
  output logic [AW-1:0] aref_a,
  output logic [AW-1:0] aref_b,
  output logic [DW-1:0] dref_a,
  output logic [DW-1:0] dref_b,
  output logic [15:0]   ctrl,
  output logic          clr_req
);
  import lsw_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      aref_a <= '0;
      aref_b <= '0;
      dref_a <= '0;
      dref_b <= '0;
      ctrl   <= '0;
    end else if (we) begin
      case (sel)
        SEL_AREF_A: aref_a <= wdata[AW-1:0];
        SEL_AREF_B: aref_b <= wdata[AW-1:0];
        SEL_DREF_A: dref_a <= wdata[DW-1:0];
        SEL_DREF_B: dref_b <= wdata[DW-1:0];
        SEL_CTRL:   ctrl   <= wdata[15:0];
        default: ;
      endcase
    end
  end

  assign clr_req = we && (sel == SEL_STAT) && wdata[0];
endmodule

// File: rtl/ldst_range_watch.sv
module ldst_range_watch #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int LANE_W = 16,
  localparam int WW    = (AW > DW) ? AW : DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [WW-1:0] cfg_wdata,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_data,
  input  logic          ri_bit,
  input  logic          gate_mode,
  output logic          wp_pulse,
  output logic          bp_pulse,
  output logic          sticky_hit
);
  import lsw_pkg::*;

  localparam int NB    = DW / 8;
  localparam int LANES = DW / LANE_W;

  logic [AW-1:0] aref_a, aref_b;
  logic [DW-1:0] dref_a, dref_b;
  logic [15:0]   ctrl;
  logic          clr_req;

  lsw_cfg_regs #(.AW(AW), .DW(DW), .WW(WW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .aref_a(aref_a), .aref_b(aref_b), .dref_a(dref_a), .dref_b(dref_b),
    .ctrl(ctrl), .clr_req(clr_req)
  );

  logic ahit_a, ahit_b;
  lsw_rng_cmp #(.W(AW)) u_acmp_a (
    .val(acc_addr), .refv(aref_a), .rel(rel_e'(ctrl[0])), .hit(ahit_a)
  );
  lsw_rng_cmp #(.W(AW)) u_acmp_b (
    .val(acc_addr), .refv(aref_b), .rel(rel_e'(ctrl[1])), .hit(ahit_b)
  );

  logic [LANES-1:0] lane_a, lane_b;
  logic             word_a, word_b;
  lsw_data_cmp #(.DW(DW), .LANE_W(LANE_W)) u_dcmp_a (
    .data(acc_data), .refv(dref_a), .bmask(ctrl[CTL_MSK +: NB]),
    .rel(rel_e'(ctrl[2])), .lane_hit(lane_a), .word_hit(word_a)
  );
  lsw_data_cmp #(.DW(DW), .LANE_W(LANE_W)) u_dcmp_b (
    .data(acc_data), .refv(dref_b), .bmask(ctrl[CTL_MSK+NB +: NB]),
    .rel(rel_e'(ctrl[3])), .lane_hit(lane_b), .word_hit(word_b)
  );

  logic addr_win, data_win, hit_c, gate_ok;

  always_comb begin
    addr_win = !ctrl[CTL_AEN] || (ahit_a && ahit_b);
    if (!ctrl[CTL_DEN])       data_win = 1'b1;
    else if (ctrl[CTL_HALF])  data_win = |(lane_a & lane_b);
    else                      data_win = word_a && word_b;
    hit_c   = acc_valid && addr_win && data_win;
    gate_ok = !gate_mode || ri_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_pulse   <= 1'b0;
      bp_pulse   <= 1'b0;
      sticky_hit <= 1'b0;
    end else begin
      wp_pulse <= hit_c;
      bp_pulse <= hit_c && gate_ok;
      if (hit_c)        sticky_hit <= 1'b1;
      else if (clr_req) sticky_hit <= 1'b0;
    end
  end
endmodule

// File: rtl/lsw_checker.sv
module lsw_checker (
  input logic        clk,
  input logic        rst,
  input logic        cfg_we,
  input logic [2:0]  cfg_sel,
  input logic        cfg_clr_bit,
  input logic        acc_valid,
  input logic        ri_bit,
  input logic        gate_mode,
  input logic        wp_pulse,
  input logic        bp_pulse,
  input logic        sticky_hit
);
  p_wp_needs_valid_r6: assert property (@(posedge clk) disable iff (rst)
    wp_pulse |-> $past(acc_valid));

  p_bp_implies_wp_r8: assert property (@(posedge clk) disable iff (rst)
    bp_pulse |-> wp_pulse);

  p_bp_gated_r8: assert property (@(posedge clk) disable iff (rst)
    bp_pulse |-> ($past(ri_bit) || !$past(gate_mode)));

  p_bp_ungated_r8: assert property (@(posedge clk) disable iff (rst)
    (wp_pulse && !$past(gate_mode)) |-> bp_pulse);

  p_sticky_sets_r9: assert property (@(posedge clk) disable iff (rst)
    wp_pulse |-> sticky_hit);

  p_sticky_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(sticky_hit) |-> $past(cfg_we && cfg_sel == 3'd5 && cfg_clr_bit));
endmodule

bind ldst_range_watch lsw_checker u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_clr_bit(cfg_wdata[0]), .acc_valid(acc_valid), .ri_bit(ri_bit),
  .gate_mode(gate_mode), .wp_pulse(wp_pulse), .bp_pulse(bp_pulse),
  .sticky_hit(sticky_hit)
);

// File: tb/sim_ldst_range_watch.sv
module sim_ldst_range_watch;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [31:0] acc_data = '0;
  logic        ri_bit = 1'b1;
  logic        gate_mode = 1'b0;
  logic        wp_pulse, bp_pulse, sticky_hit;

  int total = 0;
  int bad   = 0;

  ldst_range_watch u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_data(acc_data), .ri_bit(ri_bit), .gate_mode(gate_mode),
    .wp_pulse(wp_pulse), .bp_pulse(bp_pulse), .sticky_hit(sticky_hit)
  );

  always #(CLK_P/2) clk = ~clk;

  // {addr, data, expected wp}; half-word mode, addr in (0x1,0xE), data lanes in (0x4e20,0x9c40)
  localparam logic [64:0] TBL [10] = '{
    {32'h2, 32'h0000_5000, 1'b1},
    {32'h1, 32'h0000_5000, 1'b0},
    {32'hE, 32'h0000_5000, 1'b0},
    {32'hD, 32'h0000_5000, 1'b1},
    {32'h4, 32'h4e20_4e20, 1'b0},
    {32'h4, 32'h4e21_4e20, 1'b1},
    {32'h4, 32'hFFFF_0001, 1'b0},
    {32'h4, 32'h9c3f_0000, 1'b1},
    {32'h4, 32'h9c40_9c40, 1'b0},
    {32'h0, 32'h0000_6000, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic acc(input logic v, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_data = d;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R10 wp reset", wp_pulse, 1'b0);
    check("R10 bp reset", bp_pulse, 1'b0);
    check("R10 sticky reset", sticky_hit, 1'b0);

    // R7: after reset both windows disabled -> any access matches
    acc(1'b1, 32'h1234, 32'hdead_beef);
    check("R7 disabled windows match", wp_pulse, 1'b1);
    check("R9 sticky set", sticky_hit, 1'b1);
    wr(3'd5, 32'h1);
    check("R9 sticky cleared", sticky_hit, 1'b0);

    // table configuration
    wr(3'd0, 32'h1);
    wr(3'd1, 32'hE);
    wr(3'd2, 32'h4e20_4e20);
    wr(3'd3, 32'h9c40_9c40);
    wr(3'd4, 32'h75);
    for (int i = 0; i < 10; i++) begin
      acc(1'b1, TBL[i][64:33], TBL[i][32:1]);
      check("R2/R4/R6 table wp", wp_pulse, TBL[i][0]);
      check("R2/R4 table bp", bp_pulse, TBL[i][0]);
    end

    // R3 word mode
    wr(3'd4, 32'h65);
    acc(1'b1, 32'h4, 32'h0000_5000);
    check("R3 word mode low value", wp_pulse, 1'b0);
    acc(1'b1, 32'h4, 32'h4e21_4e20);
    check("R3 word mode inside", wp_pulse, 1'b1);

    // R5 byte mask
    acc(1'b1, 32'h4, 32'h4e20_00ff);
    check("R5 mask zero keeps bytes", wp_pulse, 1'b0);
    wr(3'd4, 32'h265);
    acc(1'b1, 32'h4, 32'h4e20_00ff);
    check("R5 mask byte1 removed", wp_pulse, 1'b1);

    // R7 data window disabled
    wr(3'd4, 32'h25);
    acc(1'b1, 32'h4, 32'hFFFF_FFFF);
    check("R7 data disabled match", wp_pulse, 1'b1);
    acc(1'b1, 32'h20, 32'hFFFF_FFFF);
    check("R7 address still checked", wp_pulse, 1'b0);

    // R1 swapped relations: A less-than 0x10, B greater-than 0x8
    wr(3'd0, 32'h10);
    wr(3'd1, 32'h8);
    wr(3'd4, 32'h22);
    acc(1'b1, 32'h9, 32'h0);
    check("R1 inside swapped", wp_pulse, 1'b1);
    acc(1'b1, 32'h8, 32'h0);
    check("R1 strict gt edge", wp_pulse, 1'b0);
    acc(1'b1, 32'h10, 32'h0);
    check("R1 strict lt edge", wp_pulse, 1'b0);

    // R6 valid low
    acc(1'b0, 32'h9, 32'h0);
    check("R6 invalid access", wp_pulse, 1'b0);

    // R8 gating
    gate_mode = 1'b1; ri_bit = 1'b0;
    acc(1'b1, 32'h9, 32'h0);
    check("R8 wp ungated", wp_pulse, 1'b1);
    check("R8 bp masked ri=0", bp_pulse, 1'b0);
    ri_bit = 1'b1;
    acc(1'b1, 32'h9, 32'h0);
    check("R8 bp masked ri=1", bp_pulse, 1'b1);
    gate_mode = 1'b0; ri_bit = 1'b0;
    acc(1'b1, 32'h9, 32'h0);
    check("R8 bp non-masked ri=0", bp_pulse, 1'b1);

    // R9 sticky behaviour
    wr(3'd5, 32'h0);
    check("R9 write 0 keeps", sticky_hit, 1'b1);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd5; cfg_wdata = 32'h1;
    acc_valid = 1'b1; acc_addr = 32'h9;
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b0;
    check("R9 match beats clear", sticky_hit, 1'b1);
    wr(3'd5, 32'h1);
    check("R9 clear alone", sticky_hit, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule